// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is one capture channel for a free-running timer. When an already synchronized and qualified input edge strobe arrives, the channel stores the current timer count in its capture register. The same strobe advances an 8-bit pulse counter. Behind the capture register sits a holding register, and behind the pulse counter sits a second holding register. Together these give software a stable snapshot while new edges keep arriving.

A mode input selects how the holding registers fill, and a buffer-enable input gates all holding-register updates.

- **Queue mode (mode = 0):** every edge pushes the previous capture into the holding register, so the two most recent timestamps are always visible.
- **Latch mode (mode = 1):** edges touch only the capture register and the pulse counter. Three external events copy both values into their holding registers in one cycle and clear the pulse counter:
  - the modulus down-counter reaching zero,
  - a zero written into the modulus count register,
  - a software latch strobe.

Every input is sampled on each clock and no input is ever stalled. The stimulus is made of single-cycle strobes, not a data stream, so there is no valid/ready pair and no back-pressure: a strobe that is high at a rising edge is consumed at that edge. All results are registered and appear on the outputs one clock after the edge that consumed the stimulus.

Top module: `bic_channel`

## Requirements
- R1: After reset, cap_value, cap_hold, pacc_value and pacc_hold all read 0.
- R2: When cap_stb is high at a clock edge, cap_value shows the tmr_count of that edge one cycle later, in either mode.
- R3: In queue mode (cap_mode = 0) with buf_en = 1, each cap_stb copies the previous cap_value into cap_hold while cap_value takes the new count.
- R4: With buf_en = 0, cap_hold and pacc_hold never change, whatever the mode, the strobes and the three latch sources.
- R5: In latch mode (cap_mode = 1), cap_stb leaves cap_hold unchanged; only a latch event updates it.
- R6: In latch mode with buf_en = 1, a high level on any of mod_zero, mod_wr_zero or sw_latch copies cap_value into cap_hold and pacc_value into pacc_hold.
- R7: A latch event clears pacc_value. If cap_stb is high in the same cycle, pacc_value becomes 1.
- R8: pacc_value increments by one on each cap_stb and holds at 255 once it reaches 255.
- R9: When a latch event and cap_stb coincide, cap_hold receives the capture value from before that edge and cap_value takes the new tmr_count.
- R10: pacc_clr forces pacc_value to 0, overriding cap_stb. It does not alter cap_value, cap_hold or pacc_hold.
- R11: In queue mode, the three latch sources are ignored: pacc_value is not cleared and pacc_hold does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_count | input | 16 | Free-running timer value |
| cap_stb | input | 1 | Qualified input edge strobe, one cycle per edge |
| cap_mode | input | 1 | 0 = queue mode, 1 = latch mode |
| buf_en | input | 1 | Enables holding-register updates |
| mod_zero | input | 1 | Modulus down-counter reached zero |
| mod_wr_zero | input | 1 | Zero written to the modulus count register |
| sw_latch | input | 1 | Software latch strobe |
| pacc_clr | input | 1 | Clears the pulse counter |
| cap_value | output | 16 | Capture register |
| cap_hold | output | 16 | Capture holding register |
| pacc_value | output | 8 | Pulse counter |
| pacc_hold | output | 8 | Pulse counter holding register |

## Verification
Every output is a single register stage away from the inputs. Each result is therefore due exactly one rising edge after the stimulus that caused it, and this holds for captures, queue pushes, latch transfers, clears and saturation alike.

The driver applies one stimulus cycle on a falling edge and records the expected register contents for the following rising edge. The monitor pops that record 2 ns after the rising edge, so every comparison falls inside the one cycle where the result is due and before the next stimulus lands. Coincident cases (an edge together with a latch event, or a clear together with an edge) are driven as single cycles so that the required ordering is observed at that one sample.

// File: rtl/bic_pkg.sv
package bic_pkg;
  typedef enum logic {
    MODE_QUEUE = 1'b0,
    MODE_LATCH = 1'b1
  } cap_mode_e;

  localparam int unsigned LATCH_SRC_N = 3;
endpackage

// File: rtl/bic_latch_ctl.sv
module bic_latch_ctl
  import bic_pkg::*;
#(
  parameter int unsigned SRC_N = LATCH_SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cap_mode_e        mode,
  input  logic             buf_en,
  input  logic [SRC_N-1:0] src,
  output logic             latch_ev,
  output logic             push_en
);
  logic [SRC_N-1:0] src_gated;
  logic             any_src;

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    assign src_gated[g] = src[g] & buf_en & (mode == MODE_LATCH);
  end

  assign any_src  = |src_gated;
  assign latch_ev = any_src;
  assign push_en  = buf_en & (mode == MODE_QUEUE);

  // Holding-register gating: with buffering off no event may reach the holds (R4)
  p_no_event_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |-> (!latch_ev && !push_en));

  // Queue mode never produces a latch transfer (R11)
  p_queue_no_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_QUEUE) |-> !latch_ev);
endmodule

// File: rtl/bic_cap_stage.sv
module bic_cap_stage #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr,
  input  logic          stb,
  input  logic          push_en,
  input  logic          latch_ev,
  output logic [TW-1:0] cap_q,
  output logic [TW-1:0] hold_q
);
  logic hold_load;

  assign hold_load = latch_ev | (push_en & stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      hold_q <= '0;
    end else begin
      if (stb)       cap_q  <= tmr;
      if (hold_load) hold_q <= cap_q;
    end
  end

  p_cap_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (cap_q == $past(tmr)));

  p_queue_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && stb) |=> (hold_q == $past(cap_q)));

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_en && !latch_ev) |=> $stable(hold_q));

  p_latch_old_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_ev && stb) |=> (hold_q == $past(cap_q) && cap_q == $past(tmr)));
endmodule

// File: rtl/bic_pacc_stage.sv
module bic_pacc_stage #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          clr,
  input  logic          latch_ev,
  output logic [AW-1:0] acc_q,
  output logic [AW-1:0] hold_q
);
  localparam logic [AW-1:0] ACC_MAX = {AW{1'b1}};

  logic [AW-1:0] acc_inc;
  logic [AW-1:0] acc_base;
  logic [AW-1:0] acc_nxt;

  assign acc_base = latch_ev ? '0 : acc_q;
  assign acc_inc  = (acc_base == ACC_MAX) ? ACC_MAX : acc_base + 1'b1;

  always_comb begin
    if (clr)      acc_nxt = '0;
    else if (stb) acc_nxt = acc_inc;
    else          acc_nxt = acc_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hold_q <= '0;
    end else begin
      acc_q <= acc_nxt;
      if (latch_ev) hold_q <= acc_q;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == ACC_MAX && stb && !clr && !latch_ev) |=> (acc_q == ACC_MAX));

  p_latch_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_ev && !clr) |=> (hold_q == $past(acc_q) && acc_q == AW'($past(stb))));

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

  p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_ev |=> $stable(hold_q));
endmodule

// File: rtl/bic_channel.sv
module bic_channel
  import bic_pkg::*;
#(
  parameter int unsigned TMR_W = 16,
  parameter int unsigned ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmr_count,
  input  logic             cap_stb,
  input  logic             cap_mode,
  input  logic             buf_en,
  input  logic             mod_zero,
  input  logic             mod_wr_zero,
  input  logic             sw_latch,
  input  logic             pacc_clr,
  output logic [TMR_W-1:0] cap_value,
  output logic [TMR_W-1:0] cap_hold,
  output logic [ACC_W-1:0] pacc_value,
  output logic [ACC_W-1:0] pacc_hold
);
  logic                   latch_ev;
  logic                   push_en;
  logic [LATCH_SRC_N-1:0] srcs;
  cap_mode_e              mode;

  assign mode = cap_mode_e'(cap_mode);
  assign srcs = {sw_latch, mod_wr_zero, mod_zero};

  bic_latch_ctl #(.SRC_N(LATCH_SRC_N)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .buf_en   (buf_en),
    .src      (srcs),
    .latch_ev (latch_ev),
    .push_en  (push_en)
  );

  bic_cap_stage #(.TW(TMR_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr      (tmr_count),
    .stb      (cap_stb),
    .push_en  (push_en),
    .latch_ev (latch_ev),
    .cap_q    (cap_value),
    .hold_q   (cap_hold)
  );

  bic_pacc_stage #(.AW(ACC_W)) u_pacc (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (cap_stb),
    .clr      (pacc_clr),
    .latch_ev (latch_ev),
    .acc_q    (pacc_value),
    .hold_q   (pacc_hold)
  );

  p_latch_copies_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && buf_en && (mod_zero || mod_wr_zero || sw_latch))
      |=> (cap_hold == $past(cap_value) && pacc_hold == $past(pacc_value)));

  p_buf_off_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |=> ($stable(cap_hold) && $stable(pacc_hold)));
endmodule

// File: tb/bic_channel_test.sv
module bic_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_count = '0;
  logic        cap_stb = 1'b0, cap_mode = 1'b0, buf_en = 1'b0;
  logic        mod_zero = 1'b0, mod_wr_zero = 1'b0, sw_latch = 1'b0, pacc_clr = 1'b0;
  logic [15:0] cap_value, cap_hold;
  logic [7:0]  pacc_value, pacc_hold;

  bic_channel uut (
    .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count), .cap_stb(cap_stb),
    .cap_mode(cap_mode), .buf_en(buf_en), .mod_zero(mod_zero),
    .mod_wr_zero(mod_wr_zero), .sw_latch(sw_latch), .pacc_clr(pacc_clr),
    .cap_value(cap_value), .cap_hold(cap_hold),
    .pacc_value(pacc_value), .pacc_hold(pacc_hold)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state derived from the requirements
  logic [15:0] m_cap = '0, m_hold = '0;
  logic [7:0]  m_acc = '0, m_acch = '0;

  logic [15:0] q_cap[$];
  logic [15:0] q_hold[$];
  logic [7:0]  q_acc[$];
  logic [7:0]  q_acch[$];
  string       q_tag[$];

  task automatic expect_now(input string tag);
    q_cap.push_back(m_cap);  q_hold.push_back(m_hold);
    q_acc.push_back(m_acc);  q_acch.push_back(m_acch);
    q_tag.push_back(tag);
  endtask

  // one stimulus cycle, driven at a falling edge
  task automatic step(input logic [15:0] t, input logic e, input logic lm,
                      input logic be, input logic mz, input logic mw,
                      input logic sw, input logic cl, input string tag);
    logic ev;
    logic [7:0] base;
    tmr_count = t; cap_stb = e; cap_mode = lm; buf_en = be;
    mod_zero = mz; mod_wr_zero = mw; sw_latch = sw; pacc_clr = cl;
    ev = lm & be & (mz | mw | sw);
    if (ev || (!lm && be && e)) m_hold = m_cap;     // R3 R5 R6 R9
    if (ev) m_acch = m_acc;                         // R6
    if (e) m_cap = t;                               // R2
    base = ev ? 8'd0 : m_acc;                       // R7
    if (cl) m_acc = 8'd0;                           // R10
    else if (e) m_acc = (base == 8'hFF) ? 8'hFF : base + 8'd1;  // R8
    else m_acc = base;
    expect_now(tag);
    @(negedge clk);
  endtask

  // monitor: compare 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (q_tag.size() > 0) begin
      logic [15:0] ec, eh;
      logic [7:0]  ea, eah;
      string       tg;
      ec = q_cap.pop_front(); eh = q_hold.pop_front();
      ea = q_acc.pop_front(); eah = q_acch.pop_front();
      tg = q_tag.pop_front();
      vectors++;
      if (cap_value !== ec || cap_hold !== eh || pacc_value !== ea || pacc_hold !== eah) begin
        errors++;
        $display("FAIL %s: got cap=%0d hold=%0d acc=%0d acch=%0d, expected cap=%0d hold=%0d acc=%0d acch=%0d",
                 tg, cap_value, cap_hold, pacc_value, pacc_hold, ec, eh, ea, eah);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(16'd0, 0, 0, 0, 0, 0, 0, 0, "R1 reset state");
    // queue mode, buffering off: holds frozen
    step(16'd100, 1, 0, 0, 0, 0, 0, 0, "R2 R4 capture with buf off");
    step(16'd200, 1, 0, 0, 0, 0, 0, 0, "R2 R4 R8 second capture");
    step(16'd210, 0, 1, 0, 1, 1, 1, 0, "R4 latch sources with buf off");
    // queue mode, buffering on
    step(16'd300, 1, 0, 1, 0, 0, 0, 0, "R3 queue push");
    step(16'd400, 1, 0, 1, 0, 0, 0, 0, "R3 queue push again");
    step(16'd410, 0, 0, 1, 1, 0, 0, 0, "R11 mod_zero ignored in queue");
    step(16'd420, 0, 0, 1, 0, 1, 1, 0, "R11 other sources ignored in queue");
    // latch mode
    step(16'd500, 1, 1, 1, 0, 0, 0, 0, "R5 edge leaves hold");
    step(16'd510, 0, 1, 1, 1, 0, 0, 0, "R6 R7 latch on mod_zero");
    step(16'd600, 1, 1, 1, 0, 0, 0, 0, "R5 R8 edge after latch");
    step(16'd650, 1, 1, 1, 0, 0, 0, 0, "R5 R8 edge after latch");
    step(16'd660, 0, 1, 1, 0, 1, 0, 0, "R6 R7 latch on mod_wr_zero");
    step(16'd700, 1, 1, 1, 0, 0, 0, 0, "R2 latch-mode capture");
    step(16'd710, 0, 1, 1, 0, 0, 1, 0, "R6 latch on sw_latch");
    step(16'd800, 1, 1, 1, 0, 0, 0, 0, "R5 edge");
    step(16'd900, 1, 1, 1, 0, 0, 1, 0, "R9 R7 latch with coincident edge");
    step(16'd950, 1, 1, 0, 1, 0, 0, 0, "R4 latch mode buf off");
    // clear
    step(16'd960, 0, 1, 1, 0, 0, 0, 1, "R10 clear");
    step(16'd970, 1, 0, 0, 0, 0, 0, 0, "R8 count from zero");
    step(16'd980, 1, 0, 0, 0, 0, 0, 1, "R10 clear beats edge");
    // saturation
    for (int i = 0; i < 260; i++)
      step(16'(1000 + i), 1, 0, 0, 0, 0, 0, 0, "R8 saturation");
    step(16'd2000, 1, 1, 1, 1, 0, 0, 0, "R7 R9 latch at saturation with edge");
    step(16'd2001, 0, 1, 1, 0, 0, 0, 0, "R6 idle check");
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule